// File: doc/BRIEF.md
# Uncacheable Store Merge Buffer

This block takes uncacheable stores from a core's store port and turns them into line-wide system-bus writes with a byte mask. Each store carries a word address, a data word, byte enables and a policy. The policy sets how the store may share a bus write with its neighbours. A strict store always goes out alone and in program order. A combining store merges with other combining stores to the same 32-byte line in any order, and a byte written twice keeps only its newest value. A burst store merges only while every new store starts above the highest byte the buffer already holds. A store that would break this rule closes the current burst, so a byte written twice reaches the bus twice.

A partly filled merge buffer stays inside the block until something forces it out: a fence store, a store to another line, a change of policy or serialize flag, or a burst-order violation. Stores that carry the serialize flag produce bus writes that are held back while the count of outstanding bus writes has reached the limit on `ser_limit`. The bus side uses a valid/ready handshake, and the bus returns one `bus_done` pulse for each write it completes.

Top module: `wc_burst_buf`

## Requirements
- R1: After reset, `bus_valid` is low, the outstanding-write count is zero, and the store port shows `st_ready` high while no store is offered.
- R2: Policy code 2'b00 (2'b11 behaves the same) is strict. Each such store becomes exactly one bus write of its own, in program order. The mask bits set are byte index `word_sel*4 + lane` for each enabled lane, where `word_sel` is `st_waddr[2:0]` and the line address is `st_waddr[29:3]`. A bus write never has an empty mask.
- R3: Policy 2'b01 is combine. Successive combining stores to one line with the same serialize flag merge into one bus write. A byte written more than once carries the last value.
- R4: Policy 2'b10 is burst. A store merges into the held burst when its lowest enabled byte index is strictly above the highest byte index already held.
- R5: A burst store whose lowest byte index is not above the held top (for example, a repeated byte) first flushes the held burst. The store then starts a new buffer, so that byte appears in two bus writes.
- R6: A store to a different line, with a different policy or a different serialize flag, flushes the held buffer as its own bus write before the store takes effect. Bus writes keep store order.
- R7: A store with `st_fence` set flushes a held buffer and is otherwise dropped. Without such an event, a partly filled buffer is held and produces no bus write.
- R8: A bus write made from serialize-flagged stores is offered only while outstanding writes are below `ser_limit`. The count rises on each accepted bus write and falls on each `bus_done`.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_line`, `bus_mask` and the masked bytes of `bus_data` hold steady.
- R10: A non-fence store with all byte enables clear is accepted at once and has no effect. A held buffer stays held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted on a cycle with st_valid high |
| st_waddr | input | 30 | Word address of the store |
| st_data | input | 32 | Store data, lane 0 in bits 7:0 |
| st_be | input | 4 | Byte enables per lane |
| st_mode | input | 2 | Policy: 00 strict, 01 combine, 10 burst, 11 strict |
| st_serial | input | 1 | Serialize flag for this store |
| st_fence | input | 1 | Serializing event; forces the buffer out |
| ser_limit | input | 4 | Outstanding-write limit for serialized writes (at least 1) |
| bus_valid | output | 1 | Bus write offered |
| bus_ready | input | 1 | Bus takes the offered write |
| bus_line | output | 27 | Line address of the bus write |
| bus_data | output | 256 | Line data, byte i in bits 8i+7:8i |
| bus_mask | output | 32 | Valid byte mask of the bus write |
| bus_done | input | 1 | One pulse per completed bus write |

## Verification
A wrong merge decision shows up as a bus write with an unexpected mask or byte. It appears on the first write after the faulty store, which can be as late as the next flushing event, because the buffer holds data until then. A bad outstanding count shows up in one of two ways. A serialized write appears while the limit is already reached, or the bus goes silent with a write stuck in the slot, which the drain timeout catches. Both appear within a few cycles of the miscount.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  typedef enum logic [1:0] {
    MODE_STRICT     = 2'b00,
    MODE_COMBINE    = 2'b01,
    MODE_BURST      = 2'b10,
    MODE_STRICT_ALT = 2'b11
  } wcb_mode_e;

  function automatic logic mode_is_strict(input logic [1:0] m);
    return (m == MODE_STRICT) || (m == MODE_STRICT_ALT);
  endfunction
endpackage

// File: rtl/wcb_lane_map.sv
module wcb_lane_map #(
  parameter int LINE_BYTES = 32,
  parameter int DATA_BYTES = 4,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LANE_W = $clog2(DATA_BYTES),
  localparam int WSEL_W = OFS_W - LANE_W
) (
  input  logic [WSEL_W-1:0]       word_sel,
  input  logic [DATA_BYTES-1:0]   be,
  input  logic [8*DATA_BYTES-1:0] data,
  output logic [LINE_BYTES-1:0]   hit,
  output logic [8*LINE_BYTES-1:0] line_data,
  output logic [OFS_W-1:0]        lo,
  output logic [OFS_W-1:0]        hi
);
  logic [LANE_W-1:0] lane_lo, lane_hi;

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_byte
    assign hit[i] = (word_sel == WSEL_W'(i / DATA_BYTES)) && be[i % DATA_BYTES];
    assign line_data[8*i +: 8] = data[8*(i % DATA_BYTES) +: 8];
  end

  always_comb begin
    lane_lo = '0;
    lane_hi = '0;
    for (int j = DATA_BYTES - 1; j >= 0; j--) begin
      if (be[j]) lane_lo = LANE_W'(j);
    end
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (be[j]) lane_hi = LANE_W'(j);
    end
  end

  assign lo = {word_sel, lane_lo};
  assign hi = {word_sel, lane_hi};
endmodule

// File: rtl/wcb_issue_slot.sv
module wcb_issue_slot #(
  parameter int LINE_W     = 27,
  parameter int LINE_BYTES = 32,
  parameter int CNT_W      = 4,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [LINE_W-1:0]       ld_line,
  input  logic [8*LINE_BYTES-1:0] ld_data,
  input  logic [LINE_BYTES-1:0]   ld_mask,
  input  logic                    ld_ser,
  input  logic [CNT_W-1:0]        limit,
  input  logic                    bus_ready,
  input  logic                    bus_done,
  output logic                    bus_valid,
  output logic [LINE_W-1:0]       bus_line,
  output logic [8*LINE_BYTES-1:0] bus_data,
  output logic [LINE_BYTES-1:0]   bus_mask,
  output logic                    slot_free
);
  logic             slot_v, slot_v_n;
  logic             slot_ser;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             fire, cap_hit;

  assign cap_hit   = (cnt == CNT_MAX) || (slot_ser && (cnt >= limit));
  assign bus_valid = slot_v && !cap_hit;
  assign fire      = bus_valid && bus_ready;
  assign slot_free = !slot_v || fire;

  always_comb begin
    slot_v_n = slot_v;
    if (fire) slot_v_n = 1'b0;
    if (load) slot_v_n = 1'b1;
    cnt_n = cnt + CNT_W'(fire) - CNT_W'(bus_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v   <= 1'b0;
      slot_ser <= 1'b0;
      cnt      <= '0;
    end else begin
      slot_v <= slot_v_n;
      cnt    <= cnt_n;
      if (load) slot_ser <= ld_ser;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      bus_line <= ld_line;
      bus_data <= ld_data;
      bus_mask <= ld_mask;
    end
  end

  // R8: a serialized issue never leaves more writes in flight than the limit
  assert_serial_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && slot_ser) |=> (cnt <= limit));
  // R8: a completion never arrives with nothing in flight
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> (cnt != '0));
  // R9: a stalled offer keeps its payload
  assert_hold_payload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> ($stable(bus_line) && $stable(bus_mask) && $stable(bus_data)));
endmodule

// File: rtl/wc_burst_buf.sv
module wc_burst_buf #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int LINE_BYTES = 32,
  parameter int CNT_W      = 4,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LANE_W = $clog2(DATA_BYTES),
  localparam int WSEL_W = OFS_W - LANE_W,
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int WA_W   = ADDR_W - LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [WA_W-1:0]         st_waddr,
  input  logic [8*DATA_BYTES-1:0] st_data,
  input  logic [DATA_BYTES-1:0]   st_be,
  input  logic [1:0]              st_mode,
  input  logic                    st_serial,
  input  logic                    st_fence,
  input  logic [CNT_W-1:0]        ser_limit,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic [LINE_W-1:0]       bus_line,
  output logic [8*LINE_BYTES-1:0] bus_data,
  output logic [LINE_BYTES-1:0]   bus_mask,
  input  logic                    bus_done
);
  import wcb_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // merge buffer state
  logic                    buf_valid, buf_valid_n;
  logic [LINE_W-1:0]       buf_line;
  logic [8*LINE_BYTES-1:0] buf_data, buf_data_n;
  logic [LINE_BYTES-1:0]   buf_mask, buf_mask_n;
  logic [1:0]              buf_mode;
  logic                    buf_ser;
  logic [OFS_W-1:0]        buf_top;

  // store decode
  logic [LINE_W-1:0]       st_line;
  logic [WSEL_W-1:0]       st_wsel;
  logic [LINE_BYTES-1:0]   st_hit;
  logic [8*LINE_BYTES-1:0] st_line_data;
  logic [OFS_W-1:0]        st_lo, st_hi;

  assign st_line = st_waddr[WA_W-1:WSEL_W];
  assign st_wsel = st_waddr[WSEL_W-1:0];

  wcb_lane_map #(.LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)) u_map (
    .word_sel(st_wsel), .be(st_be), .data(st_data),
    .hit(st_hit), .line_data(st_line_data), .lo(st_lo), .hi(st_hi));

  // control
  logic is_nop, is_strict, order_break, need_flush, flush_go;
  logic acc, acc_buf, acc_strict, slot_free, slot_load;
  logic [LINE_W-1:0]       ld_line;
  logic [8*LINE_BYTES-1:0] ld_data;
  logic [LINE_BYTES-1:0]   ld_mask;
  logic                    ld_ser;

  always_comb begin
    is_nop      = !st_fence && (st_be == '0);
    is_strict   = mode_is_strict(st_mode);
    order_break = (buf_mode == MODE_BURST) && (st_lo <= buf_top);
    need_flush  = buf_valid && st_valid && !is_nop &&
                  (st_fence || is_strict || (st_line != buf_line) ||
                   (st_mode != buf_mode) || (st_serial != buf_ser) || order_break);
    flush_go    = need_flush && slot_free;

    if (is_nop)          st_ready = 1'b1;
    else if (need_flush) st_ready = 1'b0;
    else if (st_fence)   st_ready = 1'b1;
    else if (is_strict)  st_ready = slot_free;
    else                 st_ready = 1'b1;

    acc        = st_valid && st_ready;
    acc_buf    = acc && !is_nop && !st_fence && !is_strict;
    acc_strict = acc && !is_nop && !st_fence && is_strict;
    slot_load  = flush_go || acc_strict;

    if (flush_go) begin
      ld_line = buf_line;
      ld_data = buf_data;
      ld_mask = buf_mask;
      ld_ser  = buf_ser;
    end else begin
      ld_line = st_line;
      ld_data = st_line_data;
      ld_mask = st_hit;
      ld_ser  = st_serial;
    end

    buf_valid_n = buf_valid;
    buf_mask_n  = buf_mask;
    if (flush_go) buf_valid_n = 1'b0;
    if (acc_buf) begin
      buf_valid_n = 1'b1;
      buf_mask_n  = (buf_valid ? buf_mask : '0) | st_hit;
    end
  end

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_merge
    assign buf_data_n[8*i +: 8] = st_hit[i] ? st_line_data[8*i +: 8] : buf_data[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      buf_valid <= 1'b0;
      buf_mask  <= '0;
      buf_mode  <= MODE_STRICT;
      buf_ser   <= 1'b0;
      buf_top   <= '0;
    end else begin
      buf_valid <= buf_valid_n;
      buf_mask  <= buf_mask_n;
      if (acc_buf) begin
        buf_mode <= st_mode;
        buf_ser  <= st_serial;
        buf_top  <= st_hi;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_buf) begin
      buf_line <= st_line;
      buf_data <= buf_data_n;
    end
  end

  wcb_issue_slot #(.LINE_W(LINE_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_slot (
    .clk(clk), .rst_n(rst_sync_n), .load(slot_load),
    .ld_line(ld_line), .ld_data(ld_data), .ld_mask(ld_mask), .ld_ser(ld_ser),
    .limit(ser_limit), .bus_ready(bus_ready), .bus_done(bus_done),
    .bus_valid(bus_valid), .bus_line(bus_line), .bus_data(bus_data),
    .bus_mask(bus_mask), .slot_free(slot_free));

  // R2: no bus write leaves with an empty mask
  assert_mask_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_valid |-> (bus_mask != '0));
  // R7: a held buffer is untouched while no store is offered
  assert_buf_held_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_valid && !st_valid) |=> (buf_valid && $stable(buf_mask)));
  // R5: a burst store below the held top never merges in the same cycle
  assert_no_backward_merge_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_valid && st_valid && (buf_mode == MODE_BURST) && (st_mode == MODE_BURST) &&
     !is_nop && (st_lo <= buf_top)) |-> !st_ready);
endmodule

// File: tb/wc_burst_buf_tb_top.sv
module wc_burst_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [26:0]  line;
    logic [255:0] data;
    logic [31:0]  mask;
    logic         ser;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, st_ready;
  logic [29:0]  st_waddr;
  logic [31:0]  st_data;
  logic [3:0]   st_be;
  logic [1:0]   st_mode;
  logic         st_serial, st_fence;
  logic [3:0]   ser_limit;
  logic         bus_valid, bus_ready, bus_done;
  logic [26:0]  bus_line;
  logic [255:0] bus_data;
  logic [31:0]  bus_mask;

  int checks = 0;
  int errors = 0;
  int ready_pct = 70;
  int done_pct  = 50;
  int issued = 0;
  int completed = 0;
  int cycles = 0;
  bit fired_prev = 0;
  bit finished = 0;
  exp_t exp_q[$];

  // reference model state
  bit           m_v = 0;
  logic [26:0]  m_line;
  logic [255:0] m_data;
  logic [31:0]  m_mask;
  logic [1:0]   m_mode;
  logic         m_ser;
  int           m_top;

  always #(CLK_PERIOD/2) clk = ~clk;

  wc_burst_buf dut_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_waddr(st_waddr), .st_data(st_data), .st_be(st_be), .st_mode(st_mode),
    .st_serial(st_serial), .st_fence(st_fence), .ser_limit(ser_limit),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_line(bus_line),
    .bus_data(bus_data), .bus_mask(bus_mask), .bus_done(bus_done));

  function automatic logic [255:0] expand(input logic [31:0] m);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[8*i +: 8] = {8{m[i]}};
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    if (m == 2'b01) return "R3";
    if (m == 2'b10) return "R4";
    return "R2";
  endfunction

  // expected bus writes from a store, computed from the requirements
  task automatic model(input logic [29:0] wa, input logic [31:0] d, input logic [3:0] be,
                       input logic [1:0] md, input logic ser, input logic fence);
    logic [26:0] line;
    int lo, hi;
    bit strict, brk;
    exp_t e;
    if (!fence && be == 4'b0) return;            // R10
    line = wa[29:3];
    lo = 99; hi = -1;
    for (int j = 0; j < 4; j++) if (be[j]) begin
      if (lo == 99) lo = wa[2:0]*4 + j;
      hi = wa[2:0]*4 + j;
    end
    strict = (md == 2'b00) || (md == 2'b11);
    brk = m_v && (m_mode == 2'b10) && (lo <= m_top);
    if (m_v && (fence || strict || line != m_line || md != m_mode || ser != m_ser || brk)) begin
      e.line = m_line; e.data = m_data; e.mask = m_mask; e.ser = m_ser;
      e.tag = {mode_tag(m_mode), "/", fence ? "R7" : (brk ? "R5" : "R6")};
      exp_q.push_back(e);
      m_v = 0;
    end
    if (fence) return;
    if (!m_v) begin m_mask = '0; m_data = '0; end
    for (int j = 0; j < 4; j++) if (be[j]) begin
      m_data[8*(wa[2:0]*4+j) +: 8] = d[8*j +: 8];
      m_mask[wa[2:0]*4+j] = 1'b1;
    end
    if (strict) begin
      e.line = line; e.data = m_data; e.mask = m_mask; e.ser = ser; e.tag = "R2";
      exp_q.push_back(e);
    end else begin
      m_v = 1; m_line = line; m_mode = md; m_ser = ser; m_top = hi;
    end
  endtask

  task automatic send(input logic [29:0] wa, input logic [31:0] d, input logic [3:0] be,
                      input logic [1:0] md, input logic ser, input logic fence);
    @(negedge clk);
    st_valid = 1'b1; st_waddr = wa; st_data = d; st_be = be;
    st_mode = md; st_serial = ser; st_fence = fence;
    model(wa, d, be, md, ser, fence);
    forever begin
      #2;
      if (st_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    #1 st_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || issued != completed || fired_prev) && t < 5000) begin
      @(negedge clk); t++;
    end
    check(t < 5000, "R6", "drain did not finish, pending writes", exp_q.size(), 0);
  endtask

  // bus responder and monitor
  initial begin
    bit held = 0;
    logic [26:0] h_line; logic [31:0] h_mask; logic [255:0] h_data;
    bus_ready = 1'b0; bus_done = 1'b0;
    forever begin
      @(negedge clk);
      cycles++;
      if (fired_prev) issued++;
      if (bus_done) completed++;
      fired_prev = 0;
      bus_ready = ($urandom % 100) < ready_pct;
      bus_done  = (issued > completed) && (($urandom % 100) < done_pct);
      #1;
      if (held) begin
        check(bus_valid && bus_line == h_line && bus_mask == h_mask &&
              ((bus_data ^ h_data) & expand(h_mask)) == '0,
              "R9", "stalled offer changed", {bus_valid, bus_mask}, {1'b1, h_mask});
      end
      held = bus_valid && !bus_ready;
      h_line = bus_line; h_mask = bus_mask; h_data = bus_data;
      if (bus_valid && bus_ready) begin
        fired_prev = 1;
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected bus write mask", bus_mask, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(bus_line == e.line && bus_mask == e.mask, e.tag, "bus line/mask",
                {bus_line, bus_mask}, {e.line, e.mask});
          check(((bus_data ^ e.data) & expand(e.mask)) == '0, e.tag, "bus data",
                bus_data & expand(e.mask), e.data & expand(e.mask));
          if (e.ser)
            check((issued - completed) < int'(ser_limit), "R8", "outstanding at serialized issue",
                  issued - completed, ser_limit);
        end
      end
    end
  end

  initial begin
    while (cycles < WATCHDOG) @(posedge clk);
    check(0, "R1", "watchdog expired", cycles, WATCHDOG);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; st_valid = 1'b0; st_waddr = '0; st_data = '0; st_be = '0;
    st_mode = 2'b01; st_serial = 1'b0; st_fence = 1'b0; ser_limit = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    check(!bus_valid && st_ready, "R1", "reset state valid/ready", {bus_valid, st_ready}, 2'b01);

    // R2: strict stores each alone, in order (code 00 and 11)
    send(30'h100, 32'h11223344, 4'hF, 2'b00, 0, 0);
    send(30'h100, 32'h55667788, 4'h3, 2'b11, 0, 0);
    send(30'h205, 32'hAABBCCDD, 4'h8, 2'b00, 0, 0);
    drain();

    // R3: combine with repeated byte, out of order
    send(30'h300 + 5, 32'h01020304, 4'hF, 2'b01, 0, 0);
    send(30'h300 + 1, 32'h0A0B0C0D, 4'h6, 2'b01, 0, 0);
    send(30'h300 + 5, 32'hEE000000, 4'h8, 2'b01, 0, 0);
    // R7: held without a serializing event
    repeat (6) @(negedge clk);
    #2 check(!bus_valid, "R7", "partial buffer left early", bus_valid, 0);
    // R10: empty-enable store has no effect, buffer still held
    send(30'h777, 32'hDEADBEEF, 4'h0, 2'b00, 0, 0);
    repeat (4) @(negedge clk);
    #2 check(!bus_valid, "R10", "empty store disturbed buffer", bus_valid, 0);
    send(30'h0, 32'h0, 4'h0, 2'b00, 0, 1);     // R7 fence
    drain();

    // R4: ascending burst merges; R5: repeat byte splits
    send(30'h400, 32'h000000A1, 4'h1, 2'b10, 0, 0);
    send(30'h400, 32'h0000B200, 4'h2, 2'b10, 0, 0);
    send(30'h402, 32'hC3C3C3C3, 4'hF, 2'b10, 0, 0);
    send(30'h402, 32'hD4000000, 4'h8, 2'b10, 0, 0);   // R5 rewrite of byte 11
    send(30'h401, 32'h000000E5, 4'h1, 2'b10, 0, 0);   // R5 descending
    // R6: line change, policy change, serialize change
    send(30'h408, 32'h12345678, 4'hF, 2'b10, 0, 0);
    send(30'h408 + 2, 32'h9ABCDEF0, 4'hF, 2'b01, 0, 0);
    send(30'h408 + 3, 32'h0F0F0F0F, 4'hF, 2'b01, 1, 0);
    send(30'h0, 32'h0, 4'h0, 2'b01, 0, 1);
    drain();

    // R8: serialized strict writes with slow completion
    ser_limit = 4'd1; ready_pct = 100; done_pct = 10;
    for (int k = 0; k < 12; k++) send(30'h500 + k, $urandom, 4'hF, 2'b00, 1, 0);
    drain();
    ser_limit = 4'd3; done_pct = 15;
    for (int k = 0; k < 12; k++) send(30'h520 + k, $urandom, 4'hF, 2'b00, 1, 0);
    drain();

    // random mix
    ser_limit = 4'd2; ready_pct = 60; done_pct = 40;
    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [1:0] md;
      logic [3:0] be;
      r = $urandom % 20;
      md = (r < 2) ? 2'b00 : (r < 3) ? 2'b11 : (r < 11) ? 2'b01 : 2'b10;
      be = 4'($urandom % 15) + 4'd1;
      send({26'h0A0, 1'($urandom % 2), 3'($urandom % 8)}, $urandom, be, md,
           ($urandom % 4) == 0, ($urandom % 25) == 0);
    end
    send(30'h0, 32'h0, 4'h0, 2'b01, 0, 1);
    drain();
    check(exp_q.size() == 0, "R6", "writes missing at end", exp_q.size(), 0);
    finish_run();
  end
endmodule